// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block sits between a PWM time-base counter and the dead-band stage. On every counter tick it compares the running count with two compare values, A and B. It then decides how each of its two raw outputs moves. For every output, a programmable action word gives a 2-bit action for each of these events:

- compare-A match while counting up
- compare-A match while counting down
- compare-B match while counting up
- compare-B match while counting down
- the zero point
- the period point

Setting an output on the up-count match and clearing it on the down-count match gives a pulse centred on the period point. Writing half the period into compare A gives 50 % duty.

Each compare value has a shadow copy. In shadow mode, writes go to the shadow copy, which is moved into the active copy at a selectable counter point. A continuous software override can hold either output low or high. It has its own shadow copy and load point, or it can take effect at once.

All registers are written through a single-cycle write port. The counter, its direction and its zero and period strobes come from the time-base. A `tick` enable marks the clock cycles on which the time-base advances.

Top module: `pwm_aq_unit`

## Requirements
- R1: While reset is asserted and right after its release, `out_a` and `out_b` are low, and every register, shadow copy and active copy is zero.
- R2: Write-port map:
  - Address 0 is compare A and address 1 is compare B.
  - Address 2 is the compare configuration. Bit 0 is A immediate, bit 1 is B immediate, bits 3:2 are the A load point and bits 5:4 are the B load point.
  - Address 3 is the action word for `out_a` and address 4 is the action word for `out_b`.
  - Address 5 is the force register.
  - Addresses 6 and 7 are ignored.
  - With the immediate bit at 1, a compare write reaches the active value at that clock edge.
- R3: With the immediate bit at 0, compare writes go to the shadow copy. The shadow copy is moved to the active copy on a tick whose load point matches: 00 at the zero strobe, 01 at the period strobe, 10 at either strobe, 11 never. A match on that same tick still uses the old active value.
- R4: Action codes: 00 leaves the output unchanged, 01 drives it low, 10 drives it high and 11 inverts it. The new level appears at the clock edge of the tick.
- R5: Action-word bits:
  - 1:0 zero
  - 3:2 period
  - 5:4 compare-A up
  - 7:6 compare-A down
  - 9:8 compare-B up
  - 11:10 compare-B down

  A match counts as up when `cnt_up` is 1. With compare A at half the period, the A-up action set to high and the A-down action set to low, the output is high for exactly half of each up-down period. The opposite settings on the other output make it the complement.
- R6: Compare-B matches, the zero strobe and the period strobe apply their own actions from the action word.
- R7: When several events fall on one tick, the action taken comes from the first of these whose code is not 00: compare B, then compare A, then zero, then period.
- R8: Force register fields:
  - Bits 1:0 are the force for `out_a` and bits 3:2 are the force for `out_b`.
  - Bit 4 is force immediate and bits 6:5 are the force load point, which uses the R3 encoding.
  - A force value of 01 holds the output low on every tick and 10 holds it high. Both take precedence over every event. 00 and 11 disable the force.
- R9: A force write whose bit 4 is 1 takes effect on the next tick. With bit 4 at 0, the new force value is held in a shadow copy and takes effect on the tick after it is loaded at the chosen point.
- R10: The outputs change only at the clock edge of a tick. Writes made without a tick leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base advance enable |
| cnt | input | W | Time-base count |
| cnt_up | input | 1 | 1 while the count is rising |
| at_zero | input | 1 | Count equals zero |
| at_period | input | 1 | Count equals period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| out_a | output | 1 | Raw waveform A |
| out_b | output | 1 | Raw waveform B |

## Verification
The hardest case to reach is a shadowed force or compare value that waits at a load point while an event on the same tick still acts on the old active value. Reaching it needs a write, then the right strobe, then a tick, all in that order.

Directed phases arrange each load point at a known count. A long random phase then mixes writes of every field with ticks that skip cycles, while a bench model tracks shadow and active copies and the event priority on every cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int ADDR_W = 3;
  localparam int CFG_W  = 6;
  localparam int ACT_W  = 12;
  localparam int FRC_W  = 4;
  localparam int FCFG_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ACTA  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACTB  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FORCE = 3'd5;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_BOTH   = 2'b10,
    LD_FREEZE = 2'b11
  } ld_e;

  typedef struct packed {
    logic [1:0] cb_dn;
    logic [1:0] cb_up;
    logic [1:0] ca_dn;
    logic [1:0] ca_up;
    logic [1:0] prd;
    logic [1:0] zro;
  } act_word_t;

  function automatic logic load_hit(logic [1:0] sel, logic z, logic p);
    logic hit;
    case (ld_e'(sel))
      LD_ZERO: hit = z;
      LD_PRD:  hit = p;
      LD_BOTH: hit = z | p;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic act_apply(logic cur, logic [1:0] code);
    logic nxt;
    case (act_e'(code))
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_TGL:  nxt = ~cur;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
  import pwm_aq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         at_zero,
  input  logic         at_period,
  input  logic         imm,
  input  logic [1:0]   load_sel,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] act_q
);

  logic [W-1:0] sh_q, sh_d, act_d;
  logic         load_en;

  assign load_en = tick & load_hit(load_sel, at_zero, at_period);

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (imm) begin
      if (wr) act_d = din;
    end else begin
      if (wr)      sh_d  = din;
      if (load_en) act_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
  import pwm_aq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      cnt_up,
  input  logic      match_a,
  input  logic      match_b,
  input  logic      at_zero,
  input  logic      at_period,
  input  act_word_t acts,
  input  logic [1:0] force_sel,
  output logic      out_q
);

  logic       out_d;
  logic [1:0] code;

  always_comb begin
    code = ACT_NONE;
    if (match_b) code = cnt_up ? acts.cb_up : acts.cb_dn;
    if (code == ACT_NONE && match_a) code = cnt_up ? acts.ca_up : acts.ca_dn;
    if (code == ACT_NONE && at_zero) code = acts.zro;
    if (code == ACT_NONE && at_period) code = acts.prd;
  end

  always_comb begin
    out_d = out_q;
    if (tick) begin
      if (force_sel == ACT_LOW)       out_d = 1'b0;
      else if (force_sel == ACT_HIGH) out_d = 1'b1;
      else                            out_d = act_apply(out_q, code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/pwm_aq_unit.sv
module pwm_aq_unit
  import pwm_aq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [W-1:0]      cnt,
  input  logic              cnt_up,
  input  logic              at_zero,
  input  logic              at_period,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              out_a,
  output logic              out_b
);

  localparam int NCMP = 2;
  localparam int NCH  = 2;

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [ACT_W-1:0]  acta_q, acta_d, actb_q, actb_d;
  logic [FCFG_W-1:0] fcfg_q, fcfg_d;

  logic              wr_cfg, wr_acta, wr_actb, wr_frc;
  logic [NCMP-1:0]   wr_cmp;
  logic [W-1:0]      cmp_act [NCMP];
  logic [NCMP-1:0]   match;
  logic [FRC_W-1:0]  frc_act;
  logic              frc_imm;
  logic [NCH-1:0]    outs;
  logic [W-1:0]      cmpa_act, cmpb_act;

  assign wr_cmp[0] = wr_en && (wr_addr == ADR_CMPA);
  assign wr_cmp[1] = wr_en && (wr_addr == ADR_CMPB);
  assign wr_cfg    = wr_en && (wr_addr == ADR_CFG);
  assign wr_acta   = wr_en && (wr_addr == ADR_ACTA);
  assign wr_actb   = wr_en && (wr_addr == ADR_ACTB);
  assign wr_frc    = wr_en && (wr_addr == ADR_FORCE);

  always_comb begin
    cfg_d  = cfg_q;
    acta_d = acta_q;
    actb_d = actb_q;
    fcfg_d = fcfg_q;
    if (wr_cfg)  cfg_d  = wr_data[CFG_W-1:0];
    if (wr_acta) acta_d = wr_data[ACT_W-1:0];
    if (wr_actb) actb_d = wr_data[ACT_W-1:0];
    if (wr_frc)  fcfg_d = wr_data[FRC_W+FCFG_W-1:FRC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      acta_q <= '0;
      actb_q <= '0;
      fcfg_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      acta_q <= acta_d;
      actb_q <= actb_d;
      fcfg_q <= fcfg_d;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    pwm_shadow_reg #(.W(W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .at_zero   (at_zero),
      .at_period (at_period),
      .imm       (cfg_q[i]),
      .load_sel  (cfg_q[NCMP + 2*i +: 2]),
      .wr        (wr_cmp[i]),
      .din       (wr_data),
      .act_q     (cmp_act[i])
    );
    assign match[i] = (cnt == cmp_act[i]);
  end

  assign cmpa_act = cmp_act[0];
  assign cmpb_act = cmp_act[1];

  // a force write picks its own mode; otherwise the stored mode applies
  assign frc_imm = wr_frc ? wr_data[FRC_W] : fcfg_q[0];

  pwm_shadow_reg #(.W(FRC_W)) u_frc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .at_zero   (at_zero),
    .at_period (at_period),
    .imm       (frc_imm),
    .load_sel  (fcfg_q[2:1]),
    .wr        (wr_frc),
    .din       (wr_data[FRC_W-1:0]),
    .act_q     (frc_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_aq_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_up    (cnt_up),
      .match_a   (match[0]),
      .match_b   (match[1]),
      .at_zero   (at_zero),
      .at_period (at_period),
      .acts      (act_word_t'((c == 0) ? acta_q : actb_q)),
      .force_sel (frc_act[2*c +: 2]),
      .out_q     (outs[c])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk
  import pwm_aq_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_up,
  input logic [W-1:0]      cnt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [W-1:0]      cmpa_act,
  input logic [W-1:0]      cmpb_act,
  input logic [FRC_W-1:0]  frc_act,
  input logic [ACT_W-1:0]  acta_q,
  input logic              out_a,
  input logic              out_b
);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(out_a) && $stable(out_b)));

  // R8
  force_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_act[1:0] == 2'b01) |=> !out_a);

  // R8
  force_high_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_act[3:2] == 2'b10) |=> out_b);

  // R2
  imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CMPA && cfg_q[0]) |=> (cmpa_act == $past(wr_data)));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[1] && cfg_q[5:4] == 2'b11) |=> $stable(cmpb_act));

  // R7
  b_over_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11) && cnt_up &&
     cnt == cmpb_act && cnt == cmpa_act && acta_q[9:8] == 2'b10) |=> out_a);

endmodule

bind pwm_aq_unit pwm_aq_chk #(.W(W)) u_pwm_aq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_up   (cnt_up),
  .cnt      (cnt),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cfg_q    (cfg_q),
  .cmpa_act (cmpa_act),
  .cmpb_act (cmpb_act),
  .frc_act  (frc_act),
  .acta_q   (acta_q),
  .out_a    (out_a),
  .out_b    (out_b)
);

// File: tb/test_pwm_aq_unit.sv
`timescale 1ns/1ps
module test_pwm_aq_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         cnt_up = 1'b1;
  logic         at_zero = 1'b1;
  logic         at_period = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         out_a, out_b;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int prd = 20;
  logic up_st = 1'b1;

  // bench model state
  logic [W-1:0] m_cact [2];
  logic [W-1:0] m_csh [2];
  logic [5:0]   m_cfg;
  logic [11:0]  m_acta, m_actb;
  logic [2:0]   m_fcfg;
  logic [3:0]   m_fact, m_fsh;
  logic         m_oa, m_ob;

  always #4 clk = ~clk;

  pwm_aq_unit #(.W(W)) i_pwm_aq_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .at_zero(at_zero), .at_period(at_period), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
  );

  function automatic logic f_hit(logic [1:0] s, logic z, logic p);
    return (s == 2'b00) ? z : (s == 2'b01) ? p : (s == 2'b10) ? (z | p) : 1'b0;
  endfunction

  function automatic logic f_out(logic cur, logic [11:0] a, logic up, logic ma,
                                 logic mb, logic z, logic p, logic [1:0] frc);
    logic [1:0] c;
    if (frc == 2'b01) return 1'b0;
    if (frc == 2'b10) return 1'b1;
    c = 2'b00;
    if (mb) c = up ? a[9:8] : a[11:10];
    if (c == 2'b00 && ma) c = up ? a[5:4] : a[7:6];
    if (c == 2'b00 && z) c = a[1:0];
    if (c == 2'b00 && p) c = a[3:2];
    case (c)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cact[0] = '0; m_cact[1] = '0; m_csh[0] = '0; m_csh[1] = '0;
      m_cfg = '0; m_acta = '0; m_actb = '0; m_fcfg = '0;
      m_fact = '0; m_fsh = '0; m_oa = 1'b0; m_ob = 1'b0;
    end else begin
      logic ma, mb, fimm, wf;
      logic [W-1:0] nact [2];
      logic [3:0]   nfact;
      ma = (cnt == m_cact[0]);
      mb = (cnt == m_cact[1]);
      if (tick) begin
        m_oa = f_out(m_oa, m_acta, cnt_up, ma, mb, at_zero, at_period, m_fact[1:0]);
        m_ob = f_out(m_ob, m_actb, cnt_up, ma, mb, at_zero, at_period, m_fact[3:2]);
      end
      for (int i = 0; i < 2; i++) begin
        logic wc;
        wc = wr_en && (wr_addr == 3'(i));
        nact[i] = m_cact[i];
        if (m_cfg[i]) begin
          if (wc) nact[i] = wr_data;
        end else begin
          if (tick && f_hit(m_cfg[2+2*i +: 2], at_zero, at_period)) nact[i] = m_csh[i];
          if (wc) m_csh[i] = wr_data;
        end
        m_cact[i] = nact[i];
      end
      wf = wr_en && (wr_addr == 3'd5);
      fimm = wf ? wr_data[4] : m_fcfg[0];
      nfact = m_fact;
      if (fimm) begin
        if (wf) nfact = wr_data[3:0];
      end else begin
        if (tick && f_hit(m_fcfg[2:1], at_zero, at_period)) nfact = m_fsh;
        if (wf) m_fsh = wr_data[3:0];
      end
      m_fact = nfact;
      if (wf) m_fcfg = wr_data[6:4];
      if (wr_en && wr_addr == 3'd2) m_cfg = wr_data[5:0];
      if (wr_en && wr_addr == 3'd3) m_acta = wr_data[11:0];
      if (wr_en && wr_addr == 3'd4) m_actb = wr_data[11:0];
    end
  end

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive_cnt();
    cnt       = W'(0) + W'(cnt);
    at_zero   = (cnt == 0);
    at_period = (cnt == W'(prd));
    cnt_up    = up_st;
  endtask

  task automatic restart(int p);
    prd = p; cnt = '0; up_st = 1'b1; drive_cnt();
  endtask

  // one clock: check at negedge, advance counter if last cycle ticked, drive new inputs
  task automatic cyc(logic t, logic w, logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    if (rst_n) begin
      chk(out_a, m_oa, cur_req, "out_a vs model");
      chk(out_b, m_ob, cur_req, "out_b vs model");
    end
    if (tick) begin
      if (up_st) begin
        if (int'(cnt) + 1 >= prd) begin cnt = W'(prd); up_st = 1'b0; end
        else cnt = cnt + 1'b1;
      end else begin
        if (int'(cnt) - 1 <= 0) begin cnt = '0; up_st = 1'b1; end
        else cnt = cnt - 1'b1;
      end
    end
    drive_cnt();
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, '0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    logic hold_a, hold_b;
    void'($urandom(32'h1357));
    // R1 reset state
    restart(20);
    repeat (3) @(negedge clk);
    chk(out_a, 1'b0, "R1", "out_a in reset");
    chk(out_b, 1'b0, "R1", "out_b in reset");
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 3'd0, '0);
    chk(out_a, 1'b0, "R1", "out_a after reset");
    chk(out_b, 1'b0, "R1", "out_b after reset");
    cur_req = "R1";
    run(8);

    // R5 centred complementary pulses at 50 % duty
    cur_req = "R5";
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'd10);
    wr(3'd3, 16'h0060);
    wr(3'd4, 16'h0090);
    restart(20);
    run(40);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 3'd0, '0);
      if (out_a) hi++;
      chk(out_b, ~out_a, "R5", "complement");
    end
    checks++;
    if (hi != 20) begin
      errors++;
      $display("FAIL R5 high count actual=%0d expected=20", hi);
    end

    // R4 toggle and drive codes
    cur_req = "R4";
    wr(3'd3, 16'h00F0);
    wr(3'd4, 16'h0050);
    run(90);

    // R6 compare-B, zero and period actions
    cur_req = "R6";
    wr(3'd1, 16'd5);
    wr(3'd3, 16'h0006);
    wr(3'd4, 16'h0600);
    run(90);

    // R7 priority B over A over zero
    cur_req = "R7";
    wr(3'd0, 16'd7);
    wr(3'd1, 16'd7);
    wr(3'd3, 16'h0111);
    wr(3'd4, 16'h0021);
    run(90);

    // R3 shadow compare with each load point
    cur_req = "R3";
    wr(3'd3, 16'h0060);
    wr(3'd4, 16'h0090);
    wr(3'd2, 16'h0034);
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd15);
    run(60);
    wr(3'd2, 16'h0008);
    wr(3'd0, 16'd14);
    run(60);
    wr(3'd2, 16'h000C);
    wr(3'd0, 16'd2);
    run(60);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'd9);
    run(60);

    // R2 immediate compare writes
    cur_req = "R2";
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'd4);
    run(25);
    wr(3'd0, 16'd16);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    run(45);

    // R8 immediate forces
    cur_req = "R8";
    wr(3'd5, 16'h0012);
    run(1);
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, 1'b0, 3'd0, '0);
      chk(out_a, 1'b1, "R8", "held high");
    end
    wr(3'd5, 16'h001B);
    run(1);
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, 1'b0, 3'd0, '0);
      chk(out_b, 1'b1, "R8", "b held high");
    end
    wr(3'd5, 16'h0014);
    run(50);

    // R9 shadowed force loaded at period, then at either point
    cur_req = "R9";
    wr(3'd5, 16'h0010);
    run(30);
    wr(3'd5, 16'h0021);
    run(45);
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, 3'd0, '0);
      chk(out_a, 1'b0, "R9", "shadow force low");
    end
    wr(3'd5, 16'h0048);
    run(60);
    wr(3'd5, 16'h0010);
    run(40);

    // R10 no tick, writes do not move outputs
    cur_req = "R10";
    run(7);
    cyc(1'b0, 1'b0, 3'd0, '0);
    hold_a = out_a; hold_b = out_b;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b1, 3'($urandom_range(0, 5)), 16'($urandom_range(0, 63)) | 16'h0010);
      chk(out_a, hold_a, "R10", "a stable");
      chk(out_b, hold_b, "R10", "b stable");
    end
    wr(3'd5, 16'h0010);

    // random mix
    cur_req = "R7 random";
    restart(12);
    for (int i = 0; i < 4000; i++) begin
      logic t, w;
      logic [2:0] a;
      logic [W-1:0] d;
      t = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 4) == 0);
      a = 3'($urandom_range(0, 7));
      if (a == 3'd5 && $urandom_range(0, 2) != 0) a = 3'd3;
      case (a)
        3'd0, 3'd1: d = 16'($urandom_range(0, 13));
        3'd5: d = 16'($urandom_range(0, 127));
        default: d = 16'($urandom_range(0, 65535));
      endcase
      cyc(t, w, a, d);
    end
    cyc(1'b0, 1'b0, 3'd0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule